// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block sits between a host register port and the packet memory of a network controller. The host sets up a 16-bit buffer address and a 16-bit transfer length, each loaded one byte at a time. It then streams bytes through a single data-port offset. Reads from that offset fetch from local buffer memory at an address that advances by one per byte. Writes to it fill a small on-chip staging buffer that holds an outgoing frame.

When the number of bytes written reaches the programmed length, the transfer is complete. The block then hands the staged frame to the transmitter with a one-cycle start pulse and the frame length. In the same cycle it raises the DMA-complete and transmit-OK event bits, and it clears the transmit-request bit of the command byte. The staging buffer stays frozen until the transmitter reports it is done.

A host access may be one, two or four bytes wide. Wider accesses are split into byte steps, lowest byte first. The host handshake is a request pulse, a busy level and a done pulse that carries the read data.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset, `cmdReg` is 0x01, `hostBusy`, `hostDone` and `txStart` are low, and `eventSet` is 0x00.
- R2: A byte write to offset 0x08 replaces bits 7:0 of the buffer address and one to offset 0x09 replaces bits 15:8; the other half keeps its value.
- R3: A read of offset 0x10 returns the buffer-memory byte at the current address and then adds one to the address; the address wraps from 0xFFFF to 0x0000.
- R4: `hostSize` 0, 1 and 2 select 1, 2 and 4 byte steps; the first byte is read into or written from bits 7:0, the next from bits 15:8, and so on; unused read bits are zero.
- R5: A byte write to offset 0x0A replaces bits 7:0 of the transfer length and one to offset 0x0B replaces bits 15:8, the other half being kept.
- R6: A write to offset 0x00 sets the command byte to the written value ORed with its old bit 2 and resets the count of written bytes to zero; a read of offset 0x00 returns the command byte.
- R7: When a data-port write brings the written-byte count to the transfer length, `txStart` pulses for one cycle with `txLen` equal to the length, `eventSet` pulses 0x42 in that cycle (bit 6 DMA complete, bit 1 transmit OK), and bit 2 of `cmdReg` is cleared.
- R8: The k-th byte written since the last command write is stored at staging index k and is readable combinationally through `txRdIdx`/`txRdData`.
- R9: From `txStart` until `txDone`, data-port writes are dropped: staging contents and byte count stay unchanged and no new send occurs. This includes the remaining bytes of the access that completed the transfer.
- R10: A transfer length of zero never completes and never raises `txStart`.
- R11: A read of any offset other than 0x00 and 0x10 returns zero.
- R12: A request is taken only while `hostBusy` is low; `hostDone` is a one-cycle pulse, after which `hostBusy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Access request, taken when not busy |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostOffset | input | 5 | Register offset |
| hostSize | input | 2 | 0 byte, 1 two bytes, 2 four bytes |
| hostWrData | input | 32 | Write data, lowest byte first |
| hostBusy | output | 1 | Access in progress |
| hostDone | output | 1 | Access finished, read data valid |
| hostRdData | output | 32 | Read data |
| bufRdEn | output | 1 | Buffer memory read strobe |
| bufAddr | output | 16 | Buffer memory address |
| bufRdData | input | 8 | Buffer memory byte, one cycle after the strobe |
| txStart | output | 1 | Start-send pulse |
| txLen | output | 16 | Frame length for the send |
| txRdIdx | input | 6 | Staging read index from the transmitter |
| txRdData | output | 8 | Staging byte at that index |
| txDone | input | 1 | Transmitter releases the staging buffer |
| cmdReg | output | 8 | Command byte |
| eventSet | output | 8 | Event bits, pulsed |

## Verification
The assertions assume that `txDone` is pulsed only after a send has started, and never in the same cycle as `txStart`. They also assume that buffer memory returns its byte exactly one cycle after `bufRdEn`. The stimulus keeps to both: the bench memory model registers its output on the strobe, and the bench releases the staging buffer only after it has inspected the staged bytes from a completed send. Requests are raised only while `hostBusy` is low, so the bench never relies on a request arriving mid-access being dropped.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int REG_W = 16;
  localparam logic [4:0] OFF_CMD    = 5'h00;
  localparam logic [4:0] OFF_ADDR_L = 5'h08;
  localparam logic [4:0] OFF_ADDR_H = 5'h09;
  localparam logic [4:0] OFF_CNT_L  = 5'h0A;
  localparam logic [4:0] OFF_CNT_H  = 5'h0B;
  localparam logic [4:0] OFF_DATA   = 5'h10;
  localparam logic [7:0] CMD_RST    = 8'h01;
  localparam logic [7:0] CMD_TX_BIT = 8'h04;
  localparam logic [7:0] EVT_DMA_DONE = 8'h40;
  localparam logic [7:0] EVT_TX_OK    = 8'h02;

  typedef enum logic [2:0] {S_IDLE, S_REG, S_RD_ISSUE, S_RD_CAPT, S_WR, S_FIN} ctrlState_t;

  typedef struct packed {
    logic       latch;
    logic       ldCmd;
    logic       ldAddrLo;
    logic       ldAddrHi;
    logic       ldCntLo;
    logic       ldCntHi;
    logic       capCmd;
    logic       addrInc;
    logic       capByte;
    logic       stageWr;
    logic [1:0] lane;
  } rdmaStrobe_t;
endpackage

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostReq,
  input  logic        hostWrite,
  input  logic [4:0]  hostOffset,
  input  logic [1:0]  hostSize,
  output rdmaStrobe_t stb,
  output logic        hostBusy,
  output logic        hostDone,
  output logic        bufRdEn
);
  ctrlState_t state, stateNxt;
  logic       opWrite;
  logic [4:0] opOff;
  logic [1:0] lastLane;
  logic [1:0] lane;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      opWrite  <= 1'b0;
      opOff    <= '0;
      lastLane <= '0;
      lane     <= '0;
    end else begin
      state <= stateNxt;
      if (state == S_IDLE && hostReq) begin
        opWrite <= hostWrite;
        opOff   <= hostOffset;
        lane    <= '0;
        case (hostSize)
          2'd0:    lastLane <= 2'd0;
          2'd1:    lastLane <= 2'd1;
          default: lastLane <= 2'd3;
        endcase
      end
      if (state == S_RD_CAPT || state == S_WR) lane <= lane + 2'd1;
    end
  end

  always_comb begin
    stb      = '0;
    stb.lane = lane;
    stateNxt = state;
    bufRdEn  = 1'b0;
    case (state)
      S_IDLE: if (hostReq) begin
        stb.latch = 1'b1;
        if (hostOffset == OFF_DATA) stateNxt = hostWrite ? S_WR : S_RD_ISSUE;
        else                        stateNxt = S_REG;
      end
      S_REG: begin
        if (opWrite) begin
          stb.ldCmd    = (opOff == OFF_CMD);
          stb.ldAddrLo = (opOff == OFF_ADDR_L);
          stb.ldAddrHi = (opOff == OFF_ADDR_H);
          stb.ldCntLo  = (opOff == OFF_CNT_L);
          stb.ldCntHi  = (opOff == OFF_CNT_H);
        end else begin
          stb.capCmd   = (opOff == OFF_CMD);
        end
        stateNxt = S_FIN;
      end
      S_RD_ISSUE: begin
        bufRdEn     = 1'b1;
        stb.addrInc = 1'b1;
        stateNxt    = S_RD_CAPT;
      end
      S_RD_CAPT: begin
        stb.capByte = 1'b1;
        stateNxt    = (lane == lastLane) ? S_FIN : S_RD_ISSUE;
      end
      S_WR: begin
        stb.stageWr = 1'b1;
        stateNxt    = (lane == lastLane) ? S_FIN : S_WR;
      end
      S_FIN:   stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  assign hostBusy = (state != S_IDLE);
  assign hostDone = (state == S_FIN);
endmodule

// File: rtl/rdma_datapath.sv
module rdma_datapath
  import rdma_pkg::*;
#(
  parameter int STAGE_DEPTH = 64,
  localparam int STAGE_AW = $clog2(STAGE_DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  rdmaStrobe_t         stb,
  input  logic [31:0]         hostWrData,
  output logic [31:0]         hostRdData,
  output logic [REG_W-1:0]    bufAddr,
  input  logic [7:0]          bufRdData,
  output logic                txStart,
  output logic [REG_W-1:0]    txLen,
  input  logic [STAGE_AW-1:0] txRdIdx,
  output logic [7:0]          txRdData,
  input  logic                txDone,
  output logic [7:0]          cmdReg,
  output logic [7:0]          eventSet
);
  logic [REG_W-1:0] addrQ, cntQ, wrPtr;
  logic [31:0]      wrDataQ, rdDataQ;
  logic [7:0]       cmdQ;
  logic             held;
  logic [7:0]       stageMem [STAGE_DEPTH];
  logic [7:0]       laneByte;
  logic             lastByte;
  logic             acceptWr;

  assign laneByte = wrDataQ[{stb.lane, 3'b000} +: 8];
  assign lastByte = (cntQ != '0) && ((wrPtr + 1'b1) == cntQ);
  assign acceptWr = stb.stageWr && !held;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      cntQ     <= '0;
      wrPtr    <= '0;
      wrDataQ  <= '0;
      rdDataQ  <= '0;
      cmdQ     <= CMD_RST;
      held     <= 1'b0;
      txStart  <= 1'b0;
      txLen    <= '0;
      eventSet <= '0;
    end else begin
      txStart  <= 1'b0;
      eventSet <= '0;
      if (txDone) held <= 1'b0;
      if (stb.latch) begin
        wrDataQ <= hostWrData;
        rdDataQ <= '0;
      end
      if (stb.ldAddrLo) addrQ[7:0]  <= wrDataQ[7:0];
      if (stb.ldAddrHi) addrQ[15:8] <= wrDataQ[7:0];
      if (stb.ldCntLo)  cntQ[7:0]   <= wrDataQ[7:0];
      if (stb.ldCntHi)  cntQ[15:8]  <= wrDataQ[7:0];
      if (stb.ldCmd) begin
        cmdQ  <= wrDataQ[7:0] | (cmdQ & CMD_TX_BIT);
        wrPtr <= '0;
      end
      if (stb.capCmd)  rdDataQ[7:0] <= cmdQ;
      if (stb.addrInc) addrQ <= addrQ + 1'b1;
      if (stb.capByte) rdDataQ[{stb.lane, 3'b000} +: 8] <= bufRdData;
      if (acceptWr) begin
        wrPtr <= wrPtr + 1'b1;
        if (lastByte) begin
          held     <= 1'b1;
          txStart  <= 1'b1;
          txLen    <= cntQ;
          eventSet <= EVT_DMA_DONE | EVT_TX_OK;
          cmdQ     <= cmdQ & ~CMD_TX_BIT;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acceptWr) stageMem[wrPtr[STAGE_AW-1:0]] <= laneByte;
  end

  assign txRdData   = stageMem[txRdIdx];
  assign hostRdData = rdDataQ;
  assign bufAddr    = addrQ;
  assign cmdReg     = cmdQ;
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
  import rdma_pkg::*;
#(
  parameter int STAGE_DEPTH = 64,
  localparam int STAGE_AW = $clog2(STAGE_DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostReq,
  input  logic                hostWrite,
  input  logic [4:0]          hostOffset,
  input  logic [1:0]          hostSize,
  input  logic [31:0]         hostWrData,
  output logic                hostBusy,
  output logic                hostDone,
  output logic [31:0]         hostRdData,
  output logic                bufRdEn,
  output logic [REG_W-1:0]    bufAddr,
  input  logic [7:0]          bufRdData,
  output logic                txStart,
  output logic [REG_W-1:0]    txLen,
  input  logic [STAGE_AW-1:0] txRdIdx,
  output logic [7:0]          txRdData,
  input  logic                txDone,
  output logic [7:0]          cmdReg,
  output logic [7:0]          eventSet
);
  rdmaStrobe_t stb;

  rdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostOffset(hostOffset), .hostSize(hostSize), .stb(stb),
    .hostBusy(hostBusy), .hostDone(hostDone), .bufRdEn(bufRdEn)
  );

  rdma_datapath #(.STAGE_DEPTH(STAGE_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .bufAddr(bufAddr), .bufRdData(bufRdData),
    .txStart(txStart), .txLen(txLen), .txRdIdx(txRdIdx), .txRdData(txRdData),
    .txDone(txDone), .cmdReg(cmdReg), .eventSet(eventSet)
  );
endmodule

// File: rtl/rdma_port_engine_chk.sv
module rdma_port_engine_chk (
  input logic        clk,
  input logic        rstN,
  input logic        hostDone,
  input logic        hostBusy,
  input logic        bufRdEn,
  input logic        txStart,
  input logic [15:0] txLen,
  input logic        txDone,
  input logic [7:0]  cmdReg,
  input logic [7:0]  eventSet
);
  logic sendOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        sendOpen <= 1'b0;
    else if (txStart) sendOpen <= 1'b1;
    else if (txDone)  sendOpen <= 1'b0;
  end

  // R7
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) txStart |=> !txStart);
  // R7
  evt_with_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eventSet != 8'h00) |-> (txStart && eventSet == 8'h42));
  // R7
  cmd_bit_clr_chk: assert property (@(posedge clk) disable iff (!rstN) txStart |-> !cmdReg[2]);
  // R10
  tx_len_nz_chk: assert property (@(posedge clk) disable iff (!rstN) txStart |-> (txLen != 16'h0));
  // R9
  held_no_send_chk: assert property (@(posedge clk) disable iff (!rstN) sendOpen |-> !txStart);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) hostDone |=> !hostDone);
  // R3
  buf_issue_chk: assert property (@(posedge clk) disable iff (!rstN) bufRdEn |-> (hostBusy && !hostDone));
endmodule

bind rdma_port_engine rdma_port_engine_chk u_chk (.*);

// File: tb/tb_rdma_port_engine.sv
`timescale 1ns/1ps
module tb_rdma_port_engine;
  logic        clk = 1'b0;
  logic        rstN;
  logic        hostReq, hostWrite;
  logic [4:0]  hostOffset;
  logic [1:0]  hostSize;
  logic [31:0] hostWrData;
  logic        hostBusy, hostDone;
  logic [31:0] hostRdData;
  logic        bufRdEn;
  logic [15:0] bufAddr;
  logic [7:0]  bufRdData;
  logic        txStart;
  logic [15:0] txLen;
  logic [5:0]  txRdIdx;
  logic [7:0]  txRdData;
  logic        txDone;
  logic [7:0]  cmdReg, eventSet;

  int checks = 0;
  int fails  = 0;
  int txCnt  = 0;
  bit finished = 1'b0;

  logic [32:0] expQ[$];
  string       tagQ[$];
  logic [15:0] txExpQ[$];

  always #2 clk = ~clk;

  rdma_port_engine dut (.*);

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) if (bufRdEn) bufRdData <= memByte(bufAddr);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: host results and sends
  always @(negedge clk) begin
    if (rstN && hostDone) begin
      if (expQ.size() == 0) check(1'b0, "R12 unexpected done", 32'h1, 32'h0);
      else begin
        logic [32:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (e[32]) check(hostRdData == e[31:0], t, hostRdData, e[31:0]);
      end
    end
    if (rstN && txStart) begin
      txCnt++;
      if (txExpQ.size() == 0) check(1'b0, "R10 unexpected send", 32'(txLen), 32'h0);
      else begin
        logic [15:0] l;
        l = txExpQ.pop_front();
        check(txLen == l, "R7 txLen", 32'(txLen), 32'(l));
      end
      check(eventSet == 8'h42, "R7 eventSet", 32'(eventSet), 32'h42);
    end
    if (rstN && !txStart && eventSet != 8'h00)
      check(1'b0, "R7 stray event", 32'(eventSet), 32'h0);
  end

  task automatic access(input bit wr, input logic [4:0] off, input logic [1:0] sz,
                        input logic [31:0] data, input bit chk, input logic [31:0] exp, input string tag);
    expQ.push_back({chk, exp});
    tagQ.push_back(tag);
    @(negedge clk);
    hostReq = 1'b1; hostWrite = wr; hostOffset = off; hostSize = sz; hostWrData = data;
    @(negedge clk);
    hostReq = 1'b0;
    while (!hostDone) @(negedge clk);
    @(negedge clk);
    check(!hostBusy && !hostDone, {tag, " R12 idle after done"}, {30'b0, hostBusy, hostDone}, 32'h0);
  endtask

  task automatic wr8(input logic [4:0] off, input logic [7:0] d);
    access(1'b1, off, 2'd0, {24'h0, d}, 1'b0, 32'h0, "wr");
  endtask

  task automatic wrData(input logic [1:0] sz, input logic [31:0] d);
    access(1'b1, 5'h10, sz, d, 1'b0, 32'h0, "wrData");
  endtask

  task automatic rdPort(input logic [1:0] sz, input logic [15:0] a, input string tag);
    logic [31:0] e;
    e = {24'h0, memByte(a)};
    if (sz >= 2'd1) e[15:8] = memByte(a + 16'd1);
    if (sz == 2'd2) begin
      e[23:16] = memByte(a + 16'd2);
      e[31:24] = memByte(a + 16'd3);
    end
    access(1'b0, 5'h10, sz, 32'h0, 1'b1, e, tag);
  endtask

  task automatic checkStage(input int idx, input logic [7:0] e, input string tag);
    @(negedge clk);
    txRdIdx = 6'(idx);
    #1;
    check(txRdData == e, tag, 32'(txRdData), 32'(e));
  endtask

  task automatic releaseTx();
    @(negedge clk); txDone = 1'b1;
    @(negedge clk); txDone = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; hostReq = 1'b0; hostWrite = 1'b0; hostOffset = '0; hostSize = '0;
    hostWrData = '0; txRdIdx = '0; txDone = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(cmdReg == 8'h01, "R1 cmdReg", 32'(cmdReg), 32'h01);
    check(!hostBusy && !hostDone, "R1 host idle", {30'b0, hostBusy, hostDone}, 32'h0);
    check(!txStart, "R1 txStart", 32'(txStart), 32'h0);
    check(eventSet == 8'h00, "R1 eventSet", 32'(eventSet), 32'h0);

    // R3 / R4 reads
    wr8(5'h08, 8'h34); wr8(5'h09, 8'h12);
    rdPort(2'd0, 16'h1234, "R3 byte read");
    rdPort(2'd1, 16'h1235, "R4 16-bit read");
    rdPort(2'd2, 16'h1237, "R4 32-bit read");
    // R2: low half only
    wr8(5'h08, 8'h80);
    rdPort(2'd0, 16'h1280, "R2 low half replace");
    wr8(5'h09, 8'hFF); wr8(5'h08, 8'hFF);
    rdPort(2'd1, 16'hFFFF, "R3 address wrap");
    // R11
    access(1'b0, 5'h05, 2'd2, 32'h0, 1'b1, 32'h0, "R11 other offset reads zero");
    // R6
    wr8(5'h00, 8'h0A);
    access(1'b0, 5'h00, 2'd0, 32'h0, 1'b1, 32'h0A, "R6 cmd read");
    wr8(5'h00, 8'h04); wr8(5'h00, 8'h22);
    access(1'b0, 5'h00, 2'd0, 32'h0, 1'b1, 32'h26, "R6 cmd bit2 sticky");

    // R7 / R8 completion
    wr8(5'h0A, 8'h05); wr8(5'h0B, 8'h00);
    txExpQ.push_back(16'd5);
    wrData(2'd2, 32'h44332211);
    check(txCnt == 0, "R7 no send before length", txCnt, 0);
    wrData(2'd0, 32'h00000055);
    check(txCnt == 1, "R7 send at length", txCnt, 1);
    access(1'b0, 5'h00, 2'd0, 32'h0, 1'b1, 32'h22, "R7 cmd bit2 cleared");
    checkStage(0, 8'h11, "R8 stage0"); checkStage(1, 8'h22, "R8 stage1");
    checkStage(2, 8'h33, "R8 stage2"); checkStage(3, 8'h44, "R8 stage3");
    checkStage(4, 8'h55, "R8 stage4");

    // R9 held
    wr8(5'h00, 8'h26);
    wrData(2'd0, 32'h000000AA);
    checkStage(0, 8'h11, "R9 held write dropped");
    check(txCnt == 1, "R9 no send while held", txCnt, 1);
    releaseTx();
    wr8(5'h0A, 8'h03);
    txExpQ.push_back(16'd3);
    wrData(2'd2, 32'hDDCCBBAA);
    check(txCnt == 2, "R7 send mid-access", txCnt, 2);
    checkStage(0, 8'hAA, "R8 stage0 second"); checkStage(2, 8'hCC, "R8 stage2 second");
    checkStage(3, 8'h44, "R9 tail byte dropped");
    releaseTx();

    // R10 zero length
    wr8(5'h00, 8'h00); wr8(5'h0A, 8'h00);
    wrData(2'd2, 32'h01020304); wrData(2'd2, 32'h05060708);
    check(txCnt == 2, "R10 zero length no send", txCnt, 2);

    // R5 high half replace keeps low half
    wr8(5'h0A, 8'h02); wr8(5'h0B, 8'h01); wr8(5'h0B, 8'h00);
    wr8(5'h00, 8'h00);
    txExpQ.push_back(16'd2);
    wrData(2'd1, 32'h0000BEEF);
    check(txCnt == 3, "R5 length halves", txCnt, 3);
    checkStage(0, 8'hEF, "R4 write lane0"); checkStage(1, 8'hBE, "R4 write lane1");
    releaseTx();

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R12 all accesses done", expQ.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule